// File: doc/BRIEF.md
# Random Generator Control Interface

This block is the register front end of a hardware random-word source. A host reaches it through a plain 32-bit bus with separate read and write strobes and a word address. Through that bus it can read an identity word, issue one-shot commands, set interrupt masks and auto-reseed, poll status, read an error code and pull random words out of a small FIFO.

A sequencer runs two timed operations: self-test and seeding. Each lasts a fixed, parameterised number of cycles. When one finishes, its done flag is set. If it failed, the error flag is raised and an error code is latched. An interrupt output combines the done and error flags through their masks.

Random words come from a 32-bit LFSR stub. Two input pins stand in for the health checks: one gives the self-test verdict and one reports a statistical failure while seeding. After a successful seed the FIFO fills itself one word per cycle. With auto-seeding on, a fixed number of served words starts a fresh seed without host action.

Top module: `rng_front`

## Requirements
- R1: Word address 0 (byte 0x00) reads the identity word: type code in bits 31:28, major revision in bits 15:8, minor revision in bits 7:0, all other bits zero. Unused addresses and the command register (address 1, byte 0x04) read as zero.
- R2: The control register at address 2 (byte 0x08) resets to 0x00000060. Bit 4 enables auto-seed, bit 5 masks the done interrupt and bit 6 masks the error interrupt. Only bits 6:4 are stored; all other bits read zero.
- R3: Writing command bit 0 starts a self-test. Status bit 4 (at address 3, byte 0x0C) sets exactly TEST_CYCLES clock edges after the write edge. If `st_pass` is low at completion, status bit 16 sets and the error register (address 4, byte 0x10) becomes 0x00000001.
- R4: Writing command bit 1 starts a seed. Status bit 5 sets exactly SEED_CYCLES edges after the write edge. If `stat_fail` is high at completion, status bit 16 sets and the error register becomes 0x00000008.
- R5: Command bit 4 clears both done flags, but only while no error is pending. With an error pending it changes nothing.
- R6: Command bit 5 clears both done flags, the error flag and the error register.
- R7: `irq` = (any done flag AND NOT control bit 5) OR (error flag AND NOT control bit 6). With the reset masks, `irq` stays low.
- R8: The FIFO fills one word per cycle up to FIFO_DEPTH, and only after a successful seed, while no error is pending and no operation is running. Status bits 11:8 give the fill level.
- R9: FIFO words follow the LFSR sequence. The first word is LFSR_INIT. Each following word is (previous >> 1) XOR (0x80200003 if bit 0 of the previous word was 1, else 0).
- R10: Reading address 5 (byte 0x14) returns the oldest word and removes it. A read of an empty FIFO returns zero and leaves the level at zero.
- R11: With control bit 4 set, the sequencer starts a seed by itself once RESEED_WORDS words have been read since the last seed, and sets status bit 5 when it finishes. With bit 4 clear, no seed starts however many words are read.
- R12: Start commands written while an operation is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read of address 5 pops the FIFO) |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| st_pass | input | 1 | Self-test verdict, sampled when a self-test completes |
| stat_fail | input | 1 | Statistical failure, sampled when a seed completes |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with FIFO_DEPTH 4, TEST_CYCLES 3, SEED_CYCLES 5 and RESEED_WORDS 6, and with type code 1 and revision 3.7.

The short operation lengths let the bench check the done flags on the exact cycle they set, and check that they are still clear one cycle earlier. The small FIFO fills within a few cycles, so the full level and the refill that follows each pop are both in view. A reseed count of six makes the automatic seed happen after a handful of reads; this also shows that the LFSR word sequence carries on unbroken across the seed.

// File: rtl/rng_front_pkg.sv
package rng_front_pkg;

  // word addresses (byte offset / 4)
  localparam logic [2:0] A_IDENT = 3'd0;
  localparam logic [2:0] A_CMD   = 3'd1;
  localparam logic [2:0] A_CTRL  = 3'd2;
  localparam logic [2:0] A_STAT  = 3'd3;
  localparam logic [2:0] A_ERR   = 3'd4;
  localparam logic [2:0] A_OUT   = 3'd5;

  // command bits
  localparam int C_TEST = 0;
  localparam int C_SEED = 1;
  localparam int C_CLRI = 4;
  localparam int C_CLRE = 5;

  // status bit positions
  localparam int S_TDONE = 4;
  localparam int S_SDONE = 5;
  localparam int S_LVL   = 8;
  localparam int S_ERR   = 16;

  localparam logic [31:0] ERR_SELF  = 32'h0000_0001;
  localparam logic [31:0] ERR_STAT  = 32'h0000_0008;
  localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

  typedef enum logic [1:0] {OP_IDLE, OP_TEST, OP_SEED} op_e;

  // Galois right-shift step of the word generator
  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? LFSR_TAPS : 32'h0);
  endfunction

  function automatic logic [31:0] ident_word(input logic [3:0] t,
                                             input logic [7:0] mj,
                                             input logic [7:0] mn);
    return {t, 12'h000, mj, mn};
  endfunction

endpackage

// File: rtl/rng_lfsr_src.sv
module rng_lfsr_src
  import rng_front_pkg::*;
#(
  parameter logic [31:0] INIT = 32'hACE1_2468
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  output logic [31:0] word
);

  always_ff @(posedge clk) begin
    if (!rst_n)   word <= INIT;
    else if (adv) word <= lfsr_next(word);
  end

  // a zero state would lock the generator
  assert_lfsr_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    word != 32'h0);

endmodule

// File: rtl/rng_word_fifo.sv
module rng_word_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      level <= level + LW'(do_push) - LW'(do_pop);
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (level == '0));

endmodule

// File: rtl/rng_op_seq.sv
module rng_op_seq
  import rng_front_pkg::*;
#(
  parameter int TEST_CYCLES  = 16,
  parameter int SEED_CYCLES  = 64,
  parameter int RESEED_WORDS = 1 << 20,
  localparam int LONGEST = (TEST_CYCLES > SEED_CYCLES) ? TEST_CYCLES : SEED_CYCLES,
  localparam int CW      = $clog2(LONGEST + 1),
  localparam int SW      = $clog2(RESEED_WORDS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic test_req,
  input  logic seed_req,
  input  logic auto_en,
  input  logic word_served,
  output logic busy,
  output logic test_fin,
  output logic seed_fin
);

  op_e           op;
  logic [CW-1:0] cnt;
  logic [SW-1:0] served;
  logic          auto_due, start_test, start_seed, last;

  assign auto_due   = auto_en && (served >= SW'(RESEED_WORDS));
  assign busy       = (op != OP_IDLE);
  assign start_test = !busy && test_req;
  assign start_seed = !busy && !test_req && (seed_req || auto_due);
  assign last       = busy && (cnt == '0);
  assign test_fin   = last && (op == OP_TEST);
  assign seed_fin   = last && (op == OP_SEED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op  <= OP_IDLE;
      cnt <= '0;
    end else if (start_test) begin
      op  <= OP_TEST;
      cnt <= CW'(TEST_CYCLES - 1);
    end else if (start_seed) begin
      op  <= OP_SEED;
      cnt <= CW'(SEED_CYCLES - 1);
    end else if (last) begin
      op  <= OP_IDLE;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  // words served since the last seed, saturating at the reseed threshold
  always_ff @(posedge clk) begin
    if (!rst_n)                                    served <= '0;
    else if (start_seed)                           served <= '0;
    else if (word_served && auto_en && !auto_due)  served <= served + 1'b1;
  end

  assert_busy_ignores_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last && (test_req || seed_req)) |=> (op == $past(op)));

  assert_auto_reseed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_due && !busy && !test_req) |=> (op == OP_SEED));

  assert_served_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    served <= SW'(RESEED_WORDS));

endmodule

// File: rtl/rng_front.sv
module rng_front
  import rng_front_pkg::*;
#(
  parameter logic [3:0]  TYPE_CODE    = 4'h2,
  parameter logic [7:0]  REV_MAJOR    = 8'h02,
  parameter logic [7:0]  REV_MINOR    = 8'h01,
  parameter int          FIFO_DEPTH   = 8,
  parameter int          TEST_CYCLES  = 16,
  parameter int          SEED_CYCLES  = 64,
  parameter int          RESEED_WORDS = 1 << 20,
  parameter logic [31:0] LFSR_INIT    = 32'hACE1_2468,
  localparam int         LW           = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        st_pass,
  input  logic        stat_fail,
  output logic        irq
);

  // control: [2]=mask error, [1]=mask done, [0]=auto seed
  logic [2:0]    ctrl_q;
  logic          tdone_q, sdone_q, err_q, seeded_q;
  logic [31:0]   err_code_q;

  logic          wr_cmd, test_req, seed_req, clr_int_ev, clr_err_ev;
  logic          busy, test_fin, seed_fin;
  logic          fill_go, pop_rd, word_served;
  logic [31:0]   rng_word, fifo_dout;
  logic [LW-1:0] fifo_level;
  logic [3:0]    lvl4;
  logic          fifo_full, fifo_empty;
  logic          unused_wbits;

  assign wr_cmd     = bus_wr && (bus_addr == A_CMD);
  assign test_req   = wr_cmd && bus_wdata[C_TEST];
  assign seed_req   = wr_cmd && bus_wdata[C_SEED];
  assign clr_int_ev = wr_cmd && bus_wdata[C_CLRI];
  assign clr_err_ev = wr_cmd && bus_wdata[C_CLRE];
  assign unused_wbits = ^{bus_wdata[31:7], bus_wdata[3:2]};

  rng_op_seq #(
    .TEST_CYCLES (TEST_CYCLES),
    .SEED_CYCLES (SEED_CYCLES),
    .RESEED_WORDS(RESEED_WORDS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_req   (test_req),
    .seed_req   (seed_req),
    .auto_en    (ctrl_q[0]),
    .word_served(word_served),
    .busy       (busy),
    .test_fin   (test_fin),
    .seed_fin   (seed_fin)
  );

  assign fill_go     = seeded_q && !err_q && !busy && !fifo_full;
  assign pop_rd      = bus_rd && (bus_addr == A_OUT);
  assign word_served = pop_rd && !fifo_empty;

  rng_lfsr_src #(.INIT(LFSR_INIT)) u_src (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (fill_go),
    .word (rng_word)
  );

  rng_word_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (fill_go),
    .din  (rng_word),
    .pop  (pop_rd),
    .dout (fifo_dout),
    .level(fifo_level),
    .full (fifo_full),
    .empty(fifo_empty)
  );

  assign lvl4 = 4'(fifo_level);

  // flags: a clear in the same cycle as a completion loses to the completion
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= 3'b110;
      tdone_q    <= 1'b0;
      sdone_q    <= 1'b0;
      err_q      <= 1'b0;
      err_code_q <= '0;
      seeded_q   <= 1'b0;
    end else begin
      if (bus_wr && (bus_addr == A_CTRL)) ctrl_q <= bus_wdata[6:4];
      if (clr_err_ev) begin
        tdone_q    <= 1'b0;
        sdone_q    <= 1'b0;
        err_q      <= 1'b0;
        err_code_q <= '0;
      end else if (clr_int_ev && !err_q) begin
        tdone_q <= 1'b0;
        sdone_q <= 1'b0;
      end
      if (test_fin) begin
        tdone_q <= 1'b1;
        if (!st_pass) begin
          err_q      <= 1'b1;
          err_code_q <= ERR_SELF;
        end
      end
      if (seed_fin) begin
        sdone_q  <= 1'b1;
        seeded_q <= !stat_fail;
        if (stat_fail) begin
          err_q      <= 1'b1;
          err_code_q <= ERR_STAT;
        end
      end
    end
  end

  assign irq = ((tdone_q || sdone_q) && !ctrl_q[1]) || (err_q && !ctrl_q[2]);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_IDENT: bus_rdata = ident_word(TYPE_CODE, REV_MAJOR, REV_MINOR);
      A_CTRL:  bus_rdata = {25'h0, ctrl_q, 4'h0};
      A_STAT: begin
        bus_rdata[S_TDONE]         = tdone_q;
        bus_rdata[S_SDONE]         = sdone_q;
        bus_rdata[S_LVL +: 4]      = lvl4;
        bus_rdata[S_ERR]           = err_q;
      end
      A_ERR:   bus_rdata = err_code_q;
      A_OUT:   bus_rdata = fifo_dout;
      default: bus_rdata = '0;
    endcase
  end

  assert_clr_int_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_int_ev && !clr_err_ev && err_q && !test_fin && !seed_fin)
      |=> ($stable(tdone_q) && $stable(sdone_q)));

  assert_clr_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err_ev && !test_fin && !seed_fin) |=> (!err_q && err_code_q == '0));

  assert_no_fill_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !word_served) |=> (fifo_level <= $past(fifo_level)));

  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1] && ctrl_q[2]) |-> !irq);

  assert_err_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_fin && stat_fail) |=> (err_q && err_code_q == ERR_STAT));

endmodule

// File: tb/sim_rng_front.sv
module sim_rng_front;
  localparam int DEP = 4;
  localparam int TST = 3;
  localparam int SED = 5;
  localparam int RSD = 6;
  localparam logic [31:0] INIT = 32'hACE1_2468;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        st_pass = 1'b1, stat_fail = 1'b0;
  logic        irq;

  always #10 clk = ~clk;

  rng_front #(
    .TYPE_CODE(4'h1), .REV_MAJOR(8'h03), .REV_MINOR(8'h07),
    .FIFO_DEPTH(DEP), .TEST_CYCLES(TST), .SEED_CYCLES(SED),
    .RESEED_WORDS(RSD), .LFSR_INIT(INIT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .st_pass(st_pass), .stat_fail(stat_fail), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  logic [31:0] mdl = INIT;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  // driver side of the scoreboard: expected words, own restatement of R9
  task automatic predict(input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(mdl);
      mdl = {1'b0, mdl[31:1]} ^ ({32{mdl[0]}} & 32'h8020_0003);
    end
  endtask

  // monitor side: pop a word from the design and compare with the queue head
  task automatic pop_cmp(input string tag);
    logic [31:0] d, e;
    rd(3'd5, d);
    e = exp_q.pop_front();
    check(tag, d, e);
  endtask

  task automatic rchk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    predict(40);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    rchk("R1 ident", 3'd0, 32'h1000_0307);
    rchk("R1 cmd reads zero", 3'd1, 32'h0);
    rchk("R1 unused addr", 3'd7, 32'h0);
    rchk("R2 ctrl reset", 3'd2, 32'h0000_0060);
    rchk("R3 status reset", 3'd3, 32'h0);
    rchk("R6 err reset", 3'd4, 32'h0);
    check("R7 irq reset", {31'h0, irq}, 32'h0);
    rchk("R10 empty read", 3'd5, 32'h0);
    rchk("R10 level after empty read", 3'd3, 32'h0);
    wr(3'd2, 32'hFFFF_FF8F);
    rchk("R2 only bits 6:4 stored", 3'd2, 32'h0000_0000);
    wr(3'd2, 32'h0000_0060);
    repeat (8) @(posedge clk);
    rchk("R8 no fill before seed", 3'd3, 32'h0);

    // self-test pass, exact timing
    wr(3'd1, 32'h1);
    repeat (TST - 1) @(posedge clk);
    rchk("R3 not done one cycle early", 3'd3, 32'h0);
    rchk("R3 test done on time", 3'd3, 32'h10);
    check("R7 done masked", {31'h0, irq}, 32'h0);
    wr(3'd2, 32'h40);
    #1 check("R7 done unmasked", {31'h0, irq}, 32'h1);
    wr(3'd1, 32'h10);
    rchk("R5 clr int no error", 3'd3, 32'h0);
    check("R7 irq after clear", {31'h0, irq}, 32'h0);

    // self-test fail
    st_pass = 1'b0;
    wr(3'd1, 32'h1);
    repeat (TST + 2) @(posedge clk);
    st_pass = 1'b1;
    rchk("R3 fail status", 3'd3, 32'h0001_0010);
    rchk("R3 fail code", 3'd4, 32'h1);
    wr(3'd2, 32'h20);
    #1 check("R7 error unmasked", {31'h0, irq}, 32'h1);
    wr(3'd1, 32'h10);
    rchk("R5 clr int blocked", 3'd3, 32'h0001_0010);
    wr(3'd1, 32'h20);
    rchk("R6 clr err status", 3'd3, 32'h0);
    rchk("R6 clr err code", 3'd4, 32'h0);
    check("R6 irq after clr err", {31'h0, irq}, 32'h0);

    // failed seed
    stat_fail = 1'b1;
    wr(3'd1, 32'h2);
    repeat (SED + 2) @(posedge clk);
    stat_fail = 1'b0;
    rchk("R4 stat fail code", 3'd4, 32'h8);
    repeat (8) @(posedge clk);
    rchk("R8 no fill on error", 3'd3, 32'h0001_0020);
    wr(3'd1, 32'h20);

    // good seed, self-test issued while busy
    wr(3'd1, 32'h2);
    wr(3'd1, 32'h1);
    repeat (SED - 2) @(posedge clk);
    rchk("R4 not done one cycle early", 3'd3, 32'h0);
    rchk("R4 seed done on time", 3'd3, 32'h20);
    repeat (10) @(posedge clk);
    rchk("R8 full level R12 test ignored", 3'd3, 32'h0000_0420);

    // pops with auto-seed off
    wr(3'd1, 32'h10);
    for (int i = 0; i < 8; i++) pop_cmp("R9 word sequence");
    repeat (SED + 5) @(posedge clk);
    rchk("R11 no reseed when off", 3'd3, 32'h0000_0400);

    // auto-seed on
    wr(3'd2, 32'h30);
    for (int i = 0; i < RSD; i++) pop_cmp("R10 pop order");
    repeat (SED + 8) @(posedge clk);
    rchk("R11 auto reseed done", 3'd3, 32'h0000_0420);
    for (int i = 0; i < 4; i++) pop_cmp("R9 sequence after reseed");

    finish_run();
  end

endmodule